// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

This block is the device side of a receive descriptor ring held in host memory. Each ring entry is sixteen bytes made of four 32-bit words. Word 0 holds the buffer base address. Word 1 holds a 16-bit buffer length, stored as the negative of the buffer size, in its low half and a 16-bit status in its high half. Word 2 holds the message length and word 3 is unused. The host arms an entry by writing the buffer base, minus the buffer size, and a status of 0x8000, in which bit 15 marks the entry as owned by the device.

Between frames the engine keeps re-reading the current entry over a simple memory port and holds a snapshot of it. Received bytes arrive one per cycle with a last-byte marker and error flags. When the snapshot shows device ownership, each byte is stored in the buffer at its offset. Bytes that do not fit are discarded and the frame is flagged as an overflow. After the last byte the engine writes the message length and then the status word, which clears ownership, and moves to the next entry. If the entry is host-owned when a frame begins, the whole frame is dropped and a missed-frame counter is bumped.

The ring holds 2^n entries. The value n is taken from bits 7:4 of a 16-bit ring-length input. The memory port accepts every request, and read data returns in the cycle after the read request.

Top module: `rxr_wb_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, ring_idx and miss_count are 0 and no memory write is issued.
- R2: For a frame accepted into an entry, byte k is written to buffer base + k. The write has exactly one byte enable set, 1 << ((base + k) mod 4), and bytes are written in arrival order.
- R3: Bytes at offsets at or beyond the buffer size (the negated word-1 low half) are not written, and the release status then has overflow bit 28 set (0x10 of the status high byte).
- R4: The message-length word is written to entry address + 8. Its low 12 bits hold the count of stored bytes, which includes the 4 FCS bytes carried in the stream and is capped at the buffer size. All other bits are 0.
- R5: The release word is written in full to entry address + 4. Bit 31 (ownership) is 0, bits 25:24 (start and end) are 1, bits 23:16 are 0, and the low half keeps the armed buffer length. A clean frame therefore leaves the status high byte at 0x03.
- R6: in_err is sampled only with the last byte. in_err[2] (framing) sets bit 29 (0x20), in_err[1] (CRC) sets bit 27 (0x08) and in_err[0] (buffer) sets bit 26 (0x04). in_err values on earlier bytes have no effect.
- R7: The message-length write happens in the cycle directly before the release write, and both come after every data write of the frame.
- R8: A frame that starts while the current entry is host-owned causes no memory write, leaves ring_idx unchanged and raises miss_count by one.
- R9: ring_idx advances by one after each release and wraps to 0 after entry 2^code - 1. Here code is ring_lens[7:4], clamped to MAX_LOG; the other ring_lens bits are ignored.
- R10: Entry i lives at ring_base + 16*i. An entry re-armed by the host is used by any frame that starts at least 6 cycles later.
- R11: No memory read is issued while in_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | AW | Byte address of ring entry 0, 16-byte aligned |
| ring_lens | input | 16 | Ring-length halfword; bits 7:4 give log2 of the entry count |
| in_valid | input | 1 | A received byte is present |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_err | input | 3 | Error flags with the last byte: [2] framing, [1] CRC, [0] buffer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_be | output | 4 | Byte enables for a write |
| mem_wdata | output | 32 | Write data; a byte write repeats the byte in all lanes |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| ring_idx | output | MAX_LOG | Index of the current ring entry |
| miss_count | output | MISS_W | Frames dropped because the entry was host-owned |

## Verification
The assertions assume the frame source leaves at least 6 idle cycles after each last byte. This covers the two writeback cycles and one complete poll of the next entry. They also assume the host changes an entry only while the engine is between frames, and that memory answers a read in the following cycle without stalling. The bench keeps to these limits. It waits 10 cycles after every frame and after every re-arm, sends the bytes of a frame back to back, and writes descriptors only during those gaps. It drives all-ones error flags on non-final bytes so that the last-byte sampling rule is exercised.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

   typedef enum logic [2:0] {
      ST_POLL_A  = 3'd0,
      ST_POLL_B  = 3'd1,
      ST_POLL_C  = 3'd2,
      ST_RX      = 3'd3,
      ST_DROP    = 3'd4,
      ST_WB_LEN  = 3'd5,
      ST_WB_STAT = 3'd6
   } rxr_state_e;

   // byte offsets inside one ring entry
   localparam int unsigned ENT_BASE_OFS = 0;
   localparam int unsigned ENT_CTRL_OFS = 4;
   localparam int unsigned ENT_MLEN_OFS = 8;
   localparam int unsigned ENT_SHIFT    = 4;

   // release word: ownership cleared, start/end set, error bits in high byte
   function automatic logic [31:0] rxr_release_word(input logic fram, input logic ovf,
                                                    input logic crc, input logic bufe,
                                                    input logic [15:0] buflen);
      return {1'b0, 1'b0, fram, ovf, crc, bufe, 1'b1, 1'b1, 8'h00, buflen};
   endfunction

endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
   parameter int MAX_LOG = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [3:0]         len_code,
   input  logic               advance,
   output logic [MAX_LOG-1:0] idx
);
   localparam int IDX_W = MAX_LOG;

   logic [3:0]     lg;
   logic [IDX_W:0] last_v;

   always_comb begin
      lg     = (32'(len_code) > MAX_LOG) ? 4'(MAX_LOG) : len_code;
      last_v = ((IDX_W+1)'(1) << lg) - (IDX_W+1)'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx <= '0;
      else if (advance)
         idx <= ({1'b0, idx} >= last_v) ? '0 : idx + 1'b1;
   end
endmodule

// File: rtl/rxr_desc_snap.sv
module rxr_desc_snap #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_ctrl,
   input  logic          cap_base,
   input  logic          clr,
   input  logic [31:0]   rdata,
   output logic          valid,
   output logic          own,
   output logic [15:0]   buflen,
   output logic [AW-1:0] base
);
   logic        tmp_own;
   logic [15:0] tmp_len;
   logic [14:0] unused_ctrl;

   assign unused_ctrl = rdata[30:16];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmp_own <= 1'b0;
         tmp_len <= '0;
         valid   <= 1'b0;
         own     <= 1'b0;
         buflen  <= '0;
         base    <= '0;
      end else begin
         if (cap_ctrl) begin
            tmp_own <= rdata[31];
            tmp_len <= rdata[15:0];
         end
         if (clr) begin
            valid <= 1'b0;
         end else if (cap_base) begin
            valid  <= 1'b1;
            own    <= tmp_own;
            buflen <= tmp_len;
            base   <= rdata[AW-1:0];
         end
      end
   end
endmodule

// File: rtl/rxr_fill.sv
module rxr_fill #(
   parameter int LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat,
   input  logic             first,
   input  logic [15:0]      size,
   output logic [LEN_W-1:0] off,
   output logic             room,
   output logic [LEN_W-1:0] stored,
   output logic             trunc
);
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] nxt;
   logic             trunc_q;

   always_comb begin
      off    = first ? '0 : cnt_q;
      room   = 32'(off) < 32'(size);
      nxt    = (off == '1) ? off : off + 1'b1;
      stored = trunc_q ? size[LEN_W-1:0] : cnt_q;
      trunc  = trunc_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         trunc_q <= 1'b0;
      end else if (beat) begin
         cnt_q   <= nxt;
         trunc_q <= (first ? 1'b0 : trunc_q) | ~room;
      end
   end
endmodule

// File: rtl/rxr_miss_ctr.sv
module rxr_miss_ctr #(
   parameter int W   = 8,
   parameter bit SAT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   generate
      if (SAT) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (inc && (cnt != '1))
               cnt <= cnt + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (inc)
               cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/rxr_wb_engine.sv
module rxr_wb_engine
   import rxr_pkg::*;
#(
   parameter int AW       = 32,
   parameter int MAX_LOG  = 7,
   parameter int LEN_W    = 12,
   parameter int MISS_W   = 8,
   parameter bit MISS_SAT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [AW-1:0]      ring_base,
   input  logic [15:0]        ring_lens,
   input  logic               in_valid,
   input  logic [7:0]         in_data,
   input  logic               in_last,
   input  logic [2:0]         in_err,
   output logic               mem_req,
   output logic               mem_we,
   output logic [AW-1:0]      mem_addr,
   output logic [3:0]         mem_be,
   output logic [31:0]        mem_wdata,
   input  logic [31:0]        mem_rdata,
   output logic [MAX_LOG-1:0] ring_idx,
   output logic [MISS_W-1:0]  miss_count
);
   localparam int IDX_W = MAX_LOG;

   if (MAX_LOG < 1 || MAX_LOG > 12) begin : g_bad_log
      $error("rxr_wb_engine: MAX_LOG must lie in 1..12");
   end
   if (LEN_W < 8 || LEN_W > 16) begin : g_bad_len
      $error("rxr_wb_engine: LEN_W must lie in 8..16");
   end
   if (AW < 16 || AW > 32) begin : g_bad_aw
      $error("rxr_wb_engine: AW must lie in 16..32");
   end
   if (MISS_W < 1) begin : g_bad_miss
      $error("rxr_wb_engine: MISS_W must be at least 1");
   end

   rxr_state_e st_q, st_d;

   logic             idle, start, take, beat, advance, miss_inc;
   logic             snap_valid, snap_own;
   logic [15:0]      snap_buflen, buf_size;
   logic [AW-1:0]    snap_base, ent_addr;
   logic [LEN_W-1:0] off, stored;
   logic             room, trunc;
   logic [2:0]       err_q;
   logic [11:0]      unused_lens;

   assign unused_lens = {ring_lens[15:8], ring_lens[3:0]};

   always_comb begin
      idle     = (st_q == ST_POLL_A) || (st_q == ST_POLL_B) || (st_q == ST_POLL_C);
      start    = idle && in_valid;
      take     = start && snap_valid && snap_own;
      beat     = take || ((st_q == ST_RX) && in_valid);
      advance  = (st_q == ST_WB_STAT);
      miss_inc = (start && !take && in_last) || ((st_q == ST_DROP) && in_valid && in_last);
      buf_size = ~snap_buflen + 16'd1;
      ent_addr = ring_base + (AW'(ring_idx) << ENT_SHIFT);
   end

   rxr_ring_ptr #(.MAX_LOG(MAX_LOG)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .len_code (ring_lens[7:4]),
      .advance  (advance),
      .idx      (ring_idx)
   );

   rxr_desc_snap #(.AW(AW)) u_snap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_ctrl ((st_q == ST_POLL_B) && !start),
      .cap_base ((st_q == ST_POLL_C) && !start),
      .clr      (advance),
      .rdata    (mem_rdata),
      .valid    (snap_valid),
      .own      (snap_own),
      .buflen   (snap_buflen),
      .base     (snap_base)
   );

   rxr_fill #(.LEN_W(LEN_W)) u_fill (
      .clk    (clk),
      .rst_n  (rst_n),
      .beat   (beat),
      .first  (take),
      .size   (buf_size),
      .off    (off),
      .room   (room),
      .stored (stored),
      .trunc  (trunc)
   );

   rxr_miss_ctr #(.W(MISS_W), .SAT(MISS_SAT)) u_miss (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (miss_inc),
      .cnt   (miss_count)
   );

   // error flags are taken with the final byte only
   always_ff @(posedge clk) begin
      if (!rst_n)
         err_q <= '0;
      else if (beat && in_last)
         err_q <= in_err;
   end

   // memory port steering
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_be    = '0;
      mem_wdata = '0;
      if (beat) begin
         if (room) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = snap_base + AW'(off);
            mem_be    = 4'b0001 << mem_addr[1:0];
            mem_wdata = {4{in_data}};
         end
      end else if (st_q == ST_WB_LEN) begin
         mem_req   = 1'b1;
         mem_we    = 1'b1;
         mem_addr  = ent_addr + AW'(ENT_MLEN_OFS);
         mem_be    = 4'hF;
         mem_wdata = 32'(stored);
      end else if (st_q == ST_WB_STAT) begin
         mem_req   = 1'b1;
         mem_we    = 1'b1;
         mem_addr  = ent_addr + AW'(ENT_CTRL_OFS);
         mem_be    = 4'hF;
         mem_wdata = rxr_release_word(err_q[2], trunc, err_q[1], err_q[0], snap_buflen);
      end else if (!start && (st_q == ST_POLL_A)) begin
         mem_req  = 1'b1;
         mem_addr = ent_addr + AW'(ENT_CTRL_OFS);
      end else if (!start && (st_q == ST_POLL_B)) begin
         mem_req  = 1'b1;
         mem_addr = ent_addr + AW'(ENT_BASE_OFS);
      end
   end

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_POLL_A, ST_POLL_B, ST_POLL_C: begin
            if (start) begin
               if (take) st_d = in_last ? ST_WB_LEN : ST_RX;
               else      st_d = in_last ? ST_POLL_A : ST_DROP;
            end else if (st_q == ST_POLL_A) st_d = ST_POLL_B;
            else if (st_q == ST_POLL_B)     st_d = ST_POLL_C;
            else                            st_d = ST_POLL_A;
         end
         ST_RX:      if (in_valid && in_last) st_d = ST_WB_LEN;
         ST_DROP:    if (in_valid && in_last) st_d = ST_POLL_A;
         ST_WB_LEN:  st_d = ST_WB_STAT;
         ST_WB_STAT: st_d = ST_POLL_A;
         default:    st_d = ST_POLL_A;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_POLL_A;
      else        st_q <= st_d;
   end
endmodule

// File: rtl/rxr_wb_checker.sv
module rxr_wb_checker #(
   parameter int AW     = 32,
   parameter int IDX_W  = 7,
   parameter int MISS_W = 8,
   parameter int LEN_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_last,
   input logic              mem_req,
   input logic              mem_we,
   input logic [AW-1:0]     mem_addr,
   input logic [3:0]        mem_be,
   input logic [31:0]       mem_wdata,
   input logic [IDX_W-1:0]  ring_idx,
   input logic [MISS_W-1:0] miss_count
);
   logic stat_wr, len_wr, byte_wr;

   assign stat_wr = mem_req && mem_we && (mem_be == 4'hF) && (mem_addr[3:0] == 4'h4);
   assign len_wr  = mem_req && mem_we && (mem_be == 4'hF) && (mem_addr[3:0] == 4'h8);
   assign byte_wr = mem_req && mem_we && (mem_be != 4'hF);

   p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ring_idx == '0) && (miss_count == '0));

   p_one_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
      byte_wr |-> $onehot(mem_be));

   p_len_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      len_wr |-> (mem_wdata[31:LEN_W] == '0));

   p_release_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |-> !mem_wdata[31] && (mem_wdata[25:24] == 2'b11) && (mem_wdata[23:16] == 8'h00));

   p_len_before_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |-> $past(len_wr) && ($past(mem_addr) == mem_addr + AW'(4)));

   p_miss_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_count != $past(miss_count)) |->
         ($past(in_valid && in_last) && (miss_count == $past(miss_count) + 1'b1)));

   p_idx_after_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_idx != $past(ring_idx)) |-> $past(stat_wr));

   p_no_read_in_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> !(mem_req && !mem_we));
endmodule

bind rxr_wb_engine rxr_wb_checker #(
   .AW(AW), .IDX_W(IDX_W), .MISS_W(MISS_W), .LEN_W(LEN_W)
) u_chk (.*);

// File: tb/sim_rxr_wb_engine.sv
`timescale 1ns/1ps
module sim_rxr_wb_engine;
   localparam int RING = 32'h100;
   localparam int BUFB = 32'h400;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ring_base = RING;
   logic [15:0] ring_lens = 16'hA52F;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        in_last = 1'b0;
   logic [2:0]  in_err = 3'b000;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [3:0]  mem_be;
   logic [31:0] mem_rdata = 32'h0;
   logic [6:0]  ring_idx;
   logic [7:0]  miss_count;

   int checks = 0;
   int errors = 0;
   int reads_in_frame = 0;
   bit done = 1'b0;

   logic [7:0] mem [0:4095];

   logic [31:0] qa[$];
   logic [3:0]  qb[$];
   logic [31:0] qd[$];

   int m_idx, m_miss, m_ring;
   bit armed [0:3];
   int bsize [0:3];

   always #4 clk = ~clk;

   rxr_wb_engine u0 (
      .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_lens(ring_lens),
      .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .ring_idx(ring_idx), .miss_count(miss_count)
   );

   // memory model: writes land at the edge, reads return one cycle later
   always @(posedge clk) begin
      if (mem_req && mem_we) begin
         for (int l = 0; l < 4; l++)
            if (mem_be[l]) mem[((mem_addr & 32'hFFC) + l) & 32'hFFF] <= mem_wdata[8*l +: 8];
      end else if (mem_req) begin
         mem_rdata <= {mem[(mem_addr & 32'hFFC) + 3], mem[(mem_addr & 32'hFFC) + 2],
                       mem[(mem_addr & 32'hFFC) + 1], mem[mem_addr & 32'hFFC]};
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] word_at(input int a);
      return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
   endfunction

   task automatic put_word(input int a, input logic [31:0] w);
      for (int l = 0; l < 4; l++) mem[a+l] = w[8*l +: 8];
   endtask

   // every write is compared against the model's expected sequence
   always @(negedge clk) begin
      if (rst_n && mem_req && !mem_we && in_valid) reads_in_frame++;
      if (rst_n && mem_req && mem_we) begin
         if (qa.size() == 0) begin
            chk("R8", "unexpected write addr", mem_addr, 32'hFFFF_FFFF);
         end else begin
            logic [31:0] ea, ed, mask;
            logic [3:0]  eb;
            ea = qa.pop_front(); eb = qb.pop_front(); ed = qd.pop_front();
            mask = {{8{eb[3]}}, {8{eb[2]}}, {8{eb[1]}}, {8{eb[0]}}};
            if (eb != 4'hF) begin
               chk("R2", "byte write addr", mem_addr, ea);
               chk("R2", "byte lane", {28'h0, mem_be}, {28'h0, eb});
               chk("R2", "byte data", mem_wdata & mask, ed & mask);
            end else if (ea[3:0] == 4'h8) begin
               chk("R7", "length write position", mem_addr, ea);
               chk("R4", "message length word", mem_wdata, ed);
            end else begin
               chk("R7", "release write position", mem_addr, ea);
               chk("R5", "release word", mem_wdata, ed);
            end
         end
      end
   end

   task automatic arm(input int i, input int sz);
      int d;
      d = RING + i*16;
      put_word(d, BUFB + i*128);
      put_word(d+4, {16'h8000, 16'(-sz)});
      put_word(d+8, 32'h0);
      armed[i] = 1'b1;
      bsize[i] = sz;
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #2;
   endtask

   task automatic send(input int n, input logic [2:0] err, input logic [7:0] seed,
                       input string req);
      int sz, base, d, stored, miss0;
      bit acc;
      logic [31:0] rel;
      acc = armed[m_idx];
      d = RING + m_idx*16;
      miss0 = m_miss;
      reads_in_frame = 0;
      sz = 0; stored = 0; rel = 32'h0;
      if (acc) begin
         sz = bsize[m_idx];
         base = BUFB + m_idx*128;
         for (int k = 0; k < n && k < sz; k++) begin
            logic [7:0] b;
            b = seed + 8'(k);
            qa.push_back(base + k);
            qb.push_back(4'b0001 << ((base + k) & 3));
            qd.push_back({4{b}});
         end
         stored = (n < sz) ? n : sz;
         rel = {2'b00, err[2], (n > sz), err[1], err[0], 2'b11, 8'h00, 16'(-sz)};
         qa.push_back(d + 8); qb.push_back(4'hF); qd.push_back(32'(stored));
         qa.push_back(d + 4); qb.push_back(4'hF); qd.push_back(rel);
         armed[m_idx] = 1'b0;
         m_idx = (m_idx + 1) % m_ring;
      end else begin
         m_miss++;
      end
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #2;
         in_valid = 1'b1;
         in_data  = seed + 8'(k);
         in_last  = (k == n-1);
         in_err   = (k == n-1) ? err : 3'b111;
      end
      @(posedge clk); #2;
      in_valid = 1'b0; in_last = 1'b0; in_err = 3'b000;
      idle_cycles(10);
      chk(req, "pending writes", 32'(qa.size()), 32'h0);
      chk("R9", "ring index", 32'(ring_idx), 32'(m_idx));
      chk("R8", "missed frames", 32'(miss_count), 32'(m_miss));
      chk("R11", "reads during frame", 32'(reads_in_frame), 32'h0);
      if (acc) begin
         chk("R5", "entry status in memory", word_at(d+4), rel);
         chk("R4", "entry length in memory", word_at(d+8), 32'(stored));
      end else begin
         chk("R8", "drop adds one", 32'(m_miss - miss0), 32'h1);
      end
   endtask

   task automatic do_reset(input logic [15:0] lens, input int ring_n);
      @(posedge clk); #2;
      rst_n = 1'b0;
      ring_lens = lens;
      qa.delete(); qb.delete(); qd.delete();
      m_idx = 0; m_miss = 0; m_ring = ring_n;
      for (int i = 0; i < 4; i++) armed[i] = 1'b0;
      idle_cycles(3);
      @(negedge clk);
      chk("R1", "index in reset", 32'(ring_idx), 32'h0);
      chk("R1", "miss count in reset", 32'(miss_count), 32'h0);
      chk("R1", "write in reset", {31'h0, mem_req & mem_we}, 32'h0);
      @(posedge clk); #2;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "index after reset", 32'(ring_idx), 32'h0);
      chk("R1", "write after reset", {31'h0, mem_req & mem_we}, 32'h0);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
      // ring code 2 in bits 7:4, other bits set to noise
      do_reset(16'hA52F, 4);
      for (int i = 0; i < 4; i++) arm(i, 64);
      idle_cycles(10);
      send(64, 3'b000, 8'h10, "R2");   // clean, exact fit: 0x03
      send(70, 3'b000, 8'h40, "R3");   // truncated to 64, overflow
      send(20, 3'b010, 8'h80, "R6");   // CRC error
      send(1,  3'b101, 8'hC0, "R6");   // framing + buffer, wrap to entry 0
      chk("R9", "wrap after four entries", 32'(ring_idx), 32'h0);
      send(30, 3'b000, 8'h22, "R8");   // entry 0 host-owned: dropped
      arm(0, 8);
      idle_cycles(10);
      send(12, 3'b000, 8'h55, "R10");  // re-armed entry, small buffer
      chk("R10", "index after re-armed use", 32'(ring_idx), 32'h1);

      // two-entry ring
      do_reset(16'h0010, 2);
      chk("R1", "miss count cleared", 32'(miss_count), 32'h0);
      arm(0, 64); arm(1, 64);
      idle_cycles(10);
      send(30, 3'b000, 8'h01, "R2");
      send(31, 3'b100, 8'h61, "R6");
      chk("R9", "wrap in two-entry ring", 32'(ring_idx), 32'h0);
      send(9, 3'b000, 8'h33, "R8");
      arm(0, 64);
      idle_cycles(10);
      send(5, 3'b000, 8'h77, "R10");
      chk("R10", "entry 0 reused", word_at(RING + 8), 32'h5);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog all actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule